// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block feeds transmit buffers to a downstream data mover for several channels at once. Each channel owns a circular table of buffer descriptors, kept in a descriptor memory inside the block. Software fills the memory through a plain write/read port. A channel's table starts at a base address set per channel, and the channel keeps its position as an offset from that base. After a start command, the channel fetches the descriptor at its current offset. If software has marked the descriptor as ready, the block sends the buffer pointer and length to the mover. When the mover reports the buffer as finished, the block hands the descriptor back to software by clearing its ready bit. It may then pulse an interrupt. Finally it moves to the next descriptor, or returns to the head of the table after a descriptor that carries the wrap bit.

A single fetch engine serves all channels in round-robin order, and it handles one descriptor action per cycle. What happens on a descriptor that is not ready is set per channel. With auto-stop clear, the channel waits and fetches the descriptor again on each of its rate ticks. With auto-stop set, the channel goes inactive until it gets a new start command. With circuit-emulation mode set, the channel never stalls and never stops: it issues the descriptor whether or not it is ready.

The request to the mover is a valid/ready stream. Once `mv_valid` is high, the block holds `mv_chan`, `mv_ptr` and `mv_len` unchanged until the cycle in which `mv_ready` is high. While a request is waiting, the block starts no other fetch or writeback. The completion input `done_valid` is a single-cycle pulse that cannot be back-pressured.

Top module: `txr_seq`

## Requirements
- R1: A start pulse to an inactive channel makes it active one cycle later and points it at offset 0, which is the descriptor at its base address. A start pulse to an active channel has no effect.
- R2: A descriptor word holds the ready bit at bit 50, the wrap bit at bit 49, the interrupt-enable bit at bit 48, the length at bits 47:32 and the buffer pointer at bits 31:0. A fetched descriptor that is ready raises `mv_valid` with its channel, pointer and length, and these stay stable until `mv_ready` is high.
- R3: After the mover reports completion for a channel, the engine writes the same descriptor word back with bit 50 cleared and all other bits unchanged. It then moves the offset on by one and fetches the next descriptor.
- R4: After a completed descriptor that has bit 49 set, the offset returns to 0.
- R5: With auto-stop and circuit-emulation mode both clear, a descriptor that is not ready leaves the channel active and idle. Each rate tick for that channel triggers one new fetch of the same descriptor. Rate ticks have no effect in any other state.
- R6: With auto-stop set and circuit-emulation mode clear, a descriptor that is not ready clears the channel's active flag. Only a new start pulse restarts the channel, again at offset 0.
- R7: With circuit-emulation mode set, a fetched descriptor is issued whatever its ready bit says. The channel never stalls and never stops for an empty descriptor.
- R8: A writeback of a descriptor with bit 48 set gives a pulse of exactly one cycle on that channel's `irq` bit, in the cycle after the writeback.
- R9: Fetches and writebacks that are waiting are served one per cycle. The engine picks the next waiting channel in round-robin order, starting after the last one it served. No engine action happens while a request is held on `mv_valid`.
- R10: A `done_valid` pulse naming a channel that has no buffer at the mover has no effect.
- R11: A software write stores `sw_wdata` at `sw_addr`. `sw_rdata` returns the word at the `sw_addr` of the previous cycle.
- R12: After reset, all channels are inactive, and `mv_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_cmd | input | NCH | Start pulse, one bit per channel |
| rate_tick | input | NCH | Channel-rate tick, one bit per channel |
| cfg_base | input | NCH*AW | Base address of each channel's table |
| cfg_autostop | input | NCH | Stop when a descriptor is not ready |
| cfg_ces | input | NCH | Circuit-emulation mode: issue regardless of ready |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | AW | Software address |
| sw_wdata | input | DW | Software write data |
| sw_rdata | output | DW | Registered software read data |
| mv_valid | output | 1 | Buffer request valid |
| mv_ready | input | 1 | Mover accepts the request |
| mv_chan | output | CW | Channel of the request |
| mv_ptr | output | PTR_W | Buffer pointer |
| mv_len | output | LEN_W | Buffer length |
| done_valid | input | 1 | Buffer completion pulse |
| done_chan | input | CW | Channel whose buffer completed |
| irq | output | NCH | Per-channel completion interrupt pulse |
| chan_active | output | NCH | Per-channel active flag |

## Verification
Each channel is given its own descriptor pattern. One table is fully ready and ends in a wrap; running it shows the offset going back to the head and reaching a descriptor that software has not refilled. A table whose second entry is not ready is run once with auto-stop clear and once with it set. This separates waiting for rate ticks from shutting down, and tests a restart both before and after the head descriptor is refilled. A table that is never ready is run in circuit-emulation mode while a mover stalls `mv_ready` and another channel competes for the engine. This exercises the mode override, the holding of the request under back-pressure and the round-robin order. Stray completion pulses and ticks arriving outside the waiting state show that the block ignores them.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    CH_OFF, CH_FETCH, CH_ISSUE, CH_SEND, CH_WAIT, CH_DONE
  } ch_state_t;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_ISSUE, ACT_WAIT, ACT_STOP, ACT_SEND, ACT_ADV
  } ch_act_t;
endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem #(
  parameter int DW    = 51,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata,
  input  logic          b_we,
  input  logic [DW-1:0] b_wdata
);
  logic [DW-1:0] mem [DEPTH];

  // engine port written last: it wins on a same-address collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
  end

  assign b_rdata = mem[b_addr];
endmodule

// File: rtl/txr_rr_arb.sv
module txr_rr_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          gnt_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    gnt_o = 1'b0;
    idx_o = last_i;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_i) + k) % N;
      if (!gnt_o && req_i[c]) begin
        gnt_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end
endmodule

// File: rtl/txr_chan_ctx.sv
module txr_chan_ctx #(
  parameter int OFF_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                tick_i,
  input  logic                done_i,
  input  logic                wrap_i,
  input  txr_pkg::ch_act_t    act_i,
  output txr_pkg::ch_state_t  state_o,
  output logic [OFF_W-1:0]    off_o
);
  import txr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= CH_OFF;
      off_o   <= '0;
    end else begin
      case (state_o)
        CH_OFF:   if (start_i) begin
                    state_o <= CH_FETCH;
                    off_o   <= '0;
                  end
        CH_WAIT:  if (tick_i) state_o <= CH_FETCH;
        CH_SEND:  if (done_i) state_o <= CH_DONE;
        CH_FETCH: case (act_i)
                    ACT_ISSUE: state_o <= CH_ISSUE;
                    ACT_WAIT:  state_o <= CH_WAIT;
                    ACT_STOP:  state_o <= CH_OFF;
                    default:   ;
                  endcase
        CH_ISSUE: if (act_i == ACT_SEND) state_o <= CH_SEND;
        CH_DONE:  if (act_i == ACT_ADV) begin
                    state_o <= CH_FETCH;
                    off_o   <= wrap_i ? '0 : off_o + 1'b1;
                  end
        default:  state_o <= CH_OFF;
      endcase
    end
  end
endmodule

// File: rtl/txr_seq.sv
module txr_seq #(
  parameter int NCH   = 4,
  parameter int DEPTH = 32,
  parameter int LEN_W = 16,
  parameter int PTR_W = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW   = 3 + LEN_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    start_cmd,
  input  logic [NCH-1:0]    rate_tick,
  input  logic [NCH*AW-1:0] cfg_base,
  input  logic [NCH-1:0]    cfg_autostop,
  input  logic [NCH-1:0]    cfg_ces,
  input  logic              sw_we,
  input  logic [AW-1:0]     sw_addr,
  input  logic [DW-1:0]     sw_wdata,
  output logic [DW-1:0]     sw_rdata,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [CW-1:0]     mv_chan,
  output logic [PTR_W-1:0]  mv_ptr,
  output logic [LEN_W-1:0]  mv_len,
  input  logic              done_valid,
  input  logic [CW-1:0]     done_chan,
  output logic [NCH-1:0]    irq,
  output logic [NCH-1:0]    chan_active
);
  import txr_pkg::*;

  localparam int RDY_B = DW - 1;
  localparam int WRP_B = DW - 2;
  localparam int IEN_B = DW - 3;

  ch_state_t       st    [NCH];
  logic [AW-1:0]   off   [NCH];
  ch_act_t         act_v [NCH];
  logic [NCH-1:0]  pend;
  logic [NCH-1:0]  req;
  logic            gnt;
  logic [CW-1:0]   gidx;
  logic [CW-1:0]   rr_q;
  logic            offer_q;
  logic [AW-1:0]   eng_addr;
  logic [DW-1:0]   eng_rd;
  logic            eng_we;
  logic [DW-1:0]   eng_wd;
  logic            g_done;
  logic            g_go;
  logic            accept;

  txr_desc_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .a_we    (sw_we),
    .a_addr  (sw_addr),
    .a_wdata (sw_wdata),
    .a_rdata (sw_rdata),
    .b_addr  (eng_addr),
    .b_rdata (eng_rd),
    .b_we    (eng_we),
    .b_wdata (eng_wd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    txr_chan_ctx #(.OFF_W(AW)) u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_cmd[c]),
      .tick_i  (rate_tick[c]),
      .done_i  (done_valid && (int'(done_chan) == c)),
      .wrap_i  (eng_rd[WRP_B]),
      .act_i   (act_v[c]),
      .state_o (st[c]),
      .off_o   (off[c])
    );
    assign pend[c]        = (st[c] == CH_FETCH) || (st[c] == CH_DONE);
    assign chan_active[c] = (st[c] != CH_OFF);
  end

  assign req    = offer_q ? '0 : pend;
  assign accept = offer_q && mv_ready;

  txr_rr_arb #(.N(NCH)) u_arb (
    .req_i  (req),
    .last_i (rr_q),
    .gnt_o  (gnt),
    .idx_o  (gidx)
  );

  always_comb begin
    eng_addr = cfg_base[int'(gidx)*AW +: AW] + off[gidx];
    g_done   = gnt && (st[gidx] == CH_DONE);
    g_go     = eng_rd[RDY_B] || cfg_ces[gidx];
    eng_we   = g_done;
    eng_wd   = eng_rd;
    eng_wd[RDY_B] = 1'b0;
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) act_v[c] = ACT_NONE;
    if (accept) begin
      act_v[mv_chan] = ACT_SEND;
    end else if (gnt) begin
      if (g_done)                   act_v[gidx] = ACT_ADV;
      else if (g_go)                act_v[gidx] = ACT_ISSUE;
      else if (cfg_autostop[gidx])  act_v[gidx] = ACT_STOP;
      else                          act_v[gidx] = ACT_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_q <= 1'b0;
      rr_q    <= CW'(NCH - 1);
      mv_chan <= '0;
      mv_ptr  <= '0;
      mv_len  <= '0;
      irq     <= '0;
    end else begin
      irq <= '0;
      if (accept) begin
        offer_q <= 1'b0;
      end else if (gnt) begin
        rr_q <= gidx;
        if (g_done) begin
          irq[gidx] <= eng_rd[IEN_B];
        end else if (g_go) begin
          offer_q <= 1'b1;
          mv_chan <= gidx;
          mv_ptr  <= eng_rd[PTR_W-1:0];
          mv_len  <= eng_rd[PTR_W +: LEN_W];
        end
      end
    end
  end

  assign mv_valid = offer_q;
endmodule

// File: rtl/txr_seq_chk.sv
module txr_seq_chk #(
  parameter int NCH   = 4,
  parameter int CW    = 2,
  parameter int PTR_W = 32,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   start_cmd,
  input logic [NCH-1:0]   cfg_autostop,
  input logic [NCH-1:0]   cfg_ces,
  input logic [NCH-1:0]   chan_active,
  input logic [NCH-1:0]   irq,
  input logic             mv_valid,
  input logic             mv_ready,
  input logic [CW-1:0]    mv_chan,
  input logic [PTR_W-1:0] mv_ptr,
  input logic [LEN_W-1:0] mv_len
);
  // R1
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_active & ~$past(chan_active) & ~$past(start_cmd)) == '0));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_ptr) && $stable(mv_len) && $stable(mv_chan)));

  // R6
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~chan_active & $past(chan_active) & ~$past(cfg_autostop)) == '0));

  // R7
  ces_nostop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~chan_active & $past(chan_active) & $past(cfg_ces)) == '0));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & $past(irq)) == '0));

  // R9
  req_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> chan_active[mv_chan]);
endmodule

bind txr_seq txr_seq_chk #(.NCH(NCH), .CW(CW), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_cmd    (start_cmd),
  .cfg_autostop (cfg_autostop),
  .cfg_ces      (cfg_ces),
  .chan_active  (chan_active),
  .irq          (irq),
  .mv_valid     (mv_valid),
  .mv_ready     (mv_ready),
  .mv_chan      (mv_chan),
  .mv_ptr       (mv_ptr),
  .mv_len       (mv_len)
);

// File: tb/txr_seq_test.sv
module txr_seq_test;
  localparam int NCH = 4, DEPTH = 32, AW = 5, CW = 2;
  localparam int LEN_W = 16, PTR_W = 32, DW = 3 + LEN_W + PTR_W;
  localparam int RDY = DW - 1, WRP = DW - 2, IEN = DW - 3;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] start_cmd = '0, rate_tick = '0, cfg_autostop = '0, cfg_ces = '0;
  logic [NCH*AW-1:0] cfg_base = {5'd24, 5'd16, 5'd8, 5'd0};
  logic sw_we = 0;
  logic [AW-1:0] sw_addr = '0;
  logic [DW-1:0] sw_wdata = '0, sw_rdata;
  logic mv_valid, mv_ready = 1, done_valid = 0;
  logic [CW-1:0] mv_chan, done_chan = '0;
  logic [PTR_W-1:0] mv_ptr;
  logic [LEN_W-1:0] mv_len;
  logic [NCH-1:0] irq, chan_active;

  txr_seq uut (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit cmp_on = 0, mem_ok = 0, stall_mode = 0;
  int inject = -1;

  // reference model state
  int m_st [NCH];  // 0 off 1 fetch 2 issue 3 send 4 wait 5 done
  int m_off[NCH];
  int m_rr, m_oc, acc[NCH];
  bit m_offer;
  logic [PTR_W-1:0] m_ptr;
  logic [LEN_W-1:0] m_len;
  logic [NCH-1:0] m_irq;
  logic [DW-1:0] m_mem[DEPTH];
  logic [DW-1:0] m_rdata;
  int q_ch[$], q_due[$];

  function automatic logic [DW-1:0] mk(bit r, bit w, bit ie, int len, logic [31:0] p);
    logic [DW-1:0] d;
    d = '0;
    d[RDY] = r; d[WRP] = w; d[IEN] = ie;
    d[PTR_W +: LEN_W] = LEN_W'(len);
    d[PTR_W-1:0] = p;
    return d;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic model_step();
    int cur[NCH];
    int pick, a;
    bit ewe;
    int ea;
    logic [DW-1:0] wd, ed, rnext;
    logic [NCH-1:0] irqn;
    for (int c = 0; c < NCH; c++) cur[c] = m_st[c];
    rnext = m_mem[sw_addr];
    irqn = '0; ewe = 0; ea = 0; ed = '0;
    if (m_offer) begin
      if (mv_ready) begin
        m_st[m_oc] = 3; m_offer = 0; acc[m_oc]++;
        q_ch.push_back(m_oc); q_due.push_back(cyc + LAT);
      end
    end else begin
      pick = -1;
      for (int k = 1; k <= NCH; k++) begin
        int c = (m_rr + k) % NCH;
        if (pick < 0 && (cur[c] == 1 || cur[c] == 5)) pick = c;
      end
      if (pick >= 0) begin
        m_rr = pick;
        a = (int'(cfg_base[pick*AW +: AW]) + m_off[pick]) % DEPTH;
        wd = m_mem[a];
        if (cur[pick] == 5) begin
          irqn[pick] = wd[IEN];
          ewe = 1; ea = a; ed = wd; ed[RDY] = 0;
          m_off[pick] = wd[WRP] ? 0 : (m_off[pick] + 1) % DEPTH;
          m_st[pick] = 1;
        end else if (wd[RDY] || cfg_ces[pick]) begin
          m_offer = 1; m_oc = pick; m_ptr = wd[PTR_W-1:0]; m_len = wd[PTR_W +: LEN_W];
          m_st[pick] = 2;
        end else if (cfg_autostop[pick]) m_st[pick] = 0;
        else m_st[pick] = 4;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (cur[c] == 0 && start_cmd[c]) begin m_st[c] = 1; m_off[c] = 0; end
      if (cur[c] == 4 && rate_tick[c]) m_st[c] = 1;
      if (cur[c] == 3 && done_valid && int'(done_chan) == c) m_st[c] = 5;
    end
    if (sw_we) m_mem[sw_addr] = sw_wdata;
    if (ewe) m_mem[ea] = ed;
    m_irq = irqn;
    m_rdata = rnext;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_st[c] = 0; m_off[c] = 0; acc[c] = 0; end
      m_rr = NCH - 1; m_offer = 0; m_oc = 0; m_irq = '0;
    end else model_step();
  end

  // watchdog and cycle count
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      finish_run();
    end
  end

  // data mover: ready pattern and delayed completions
  always @(negedge clk) begin
    mv_ready <= stall_mode ? (cyc % 3 == 0) : 1'b1;
    done_valid <= 0;
    if (inject >= 0) begin
      done_valid <= 1; done_chan <= CW'(inject); inject = -1;
    end else if (q_ch.size() > 0 && q_due[0] <= cyc) begin
      done_valid <= 1; done_chan <= CW'(q_ch[0]);
      void'(q_ch.pop_front()); void'(q_due.pop_front());
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(mv_valid === m_offer, "R2 R9 mv_valid", mv_valid, m_offer);
      if (m_offer) begin
        chk(mv_chan === CW'(m_oc), "R9 mv_chan", mv_chan, m_oc);
        chk(mv_ptr === m_ptr && mv_len === m_len, "R2 mv_ptr/len", {mv_len, mv_ptr}, {m_len, m_ptr});
      end
      chk(irq === m_irq, "R8 irq", irq, m_irq);
      for (int c = 0; c < NCH; c++)
        chk(chan_active[c] === (m_st[c] != 0), "R1 R6 chan_active", chan_active[c], m_st[c] != 0);
      if (mem_ok) chk(sw_rdata === m_rdata, "R3 R11 sw_rdata", sw_rdata, m_rdata);
    end
  end

  task automatic step();
    @(negedge clk);
    start_cmd = '0; rate_tick = '0; sw_we = 0;
    sw_addr = AW'(cyc % DEPTH);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    step();
    sw_we = 1; sw_addr = AW'(a); sw_wdata = d;
  endtask

  task automatic pulse_start(int c);
    step(); start_cmd[c] = 1'b1;
  endtask

  task automatic pulse_tick(int c);
    step(); rate_tick[c] = 1'b1;
  endtask

  initial begin
    idle(3);
    // R12 reset state
    chk(chan_active === '0, "R12 reset active", chan_active, 0);
    chk(mv_valid === 1'b0, "R12 reset mv_valid", mv_valid, 0);
    chk(irq === '0, "R12 reset irq", irq, 0);
    rst_n = 1;
    @(posedge clk);
    cmp_on = 1;
    for (int a = 0; a < DEPTH; a++) wr(a, '0);
    step();
    mem_ok = 1;

    // channel 0: full ring with wrap, then stall and resume
    wr(0, mk(1, 0, 0, 100, 32'hA000_0000));
    wr(1, mk(1, 0, 1, 200, 32'hA000_0100));
    wr(2, mk(1, 1, 0, 300, 32'hA000_0200));
    pulse_start(0);
    pulse_tick(1);          // R5 tick on an inactive channel: no effect
    idle(60);
    chk(acc[0] == 3, "R4 buffers before wrap", acc[0], 3);
    chk(chan_active[0] === 1'b1 && mv_valid === 1'b0, "R5 waiting after wrap", {chan_active[0], mv_valid}, 2);
    pulse_start(0);         // R1 start while active: ignored
    wr(0, mk(1, 0, 1, 111, 32'hA000_0300));
    idle(5);
    chk(acc[0] == 3, "R5 no fetch without tick", acc[0], 3);
    pulse_tick(0);
    idle(40);
    chk(acc[0] == 4, "R5 resumed after tick", acc[0], 4);

    // channel 1: auto-stop and restart
    cfg_autostop[1] = 1'b1;
    wr(8, mk(1, 0, 1, 64, 32'hB000_0000));
    wr(9, mk(0, 1, 0, 65, 32'hB000_0100));
    pulse_start(1);
    idle(40);
    chk(chan_active[1] === 1'b0 && acc[1] == 1, "R6 stopped on empty", {chan_active[1], 8'(acc[1])}, 1);
    inject = 1;             // R10 stray completion for an idle channel
    idle(5);
    chk(chan_active[1] === 1'b0, "R10 stray done ignored", chan_active[1], 0);
    pulse_start(1);
    idle(20);
    chk(acc[1] == 1 && chan_active[1] === 1'b0, "R6 restart hits cleared head", acc[1], 1);
    wr(8, mk(1, 0, 0, 66, 32'hB000_0200));
    pulse_start(1);
    idle(40);
    chk(acc[1] == 2, "R6 restart after refill", acc[1], 2);

    // channel 2 in circuit-emulation mode against channel 3, mover stalling
    cfg_ces[2] = 1'b1; cfg_autostop[2] = 1'b1;
    stall_mode = 1;
    wr(16, mk(0, 1, 1, 50, 32'hC000_0000));
    wr(24, mk(1, 0, 1, 70, 32'hD000_0000));
    wr(25, mk(1, 1, 0, 71, 32'hD000_0100));
    step(); start_cmd = 4'b1100;
    idle(80);
    chk(acc[2] >= 3, "R7 empty descriptor still issued", acc[2], 3);
    chk(chan_active[2] === 1'b1, "R7 never stops", chan_active[2], 1);
    chk(acc[3] == 2, "R9 competing channel served", acc[3], 2);
    step(); cfg_ces[2] = 1'b0;
    idle(60);
    chk(chan_active[2] === 1'b0, "R6 stop once mode cleared", chan_active[2], 0);
    stall_mode = 0;
    idle(10);
    finish_run();
  end
endmodule